// File: doc/BRIEF.md
# Parallel Register Write Front End

This block is the parallel-bus entry point of a many-channel output device. An external host drives a chip select, an active-low write strobe, a 12-bit data word, a 6-bit channel address, a 2-bit register-type code and a bank select. These are asynchronous to the system clock, so they are first passed through a two-flop synchronizer. A small capture state machine then finds each completed strobe. It decodes the destination register and pushes one command word into an 8-entry FIFO. A downstream calibration engine drains the FIFO through a valid/ready pair. The engine holds ready low while it is busy, and writes that arrive in that time wait in the queue.

In toggle mode, a write to the input data register goes to bank B when the bank select input is high, and to bank A when it is low. In normal mode every data write goes to bank A. When a write arrives and the queue is full, the write is discarded and a sticky overflow flag is raised. While the device runs its internal reset sequence, the interface ignores all writes and empties the queue.

The capture state machine has four states:
- ST_HALT: a reset sequence is running.
- ST_WAIT: waiting for the strobe to go low.
- ST_LOW: the strobe is low.
- ST_COMMIT: a one-cycle push slot.

Its transitions are:
- Any state goes to ST_HALT while the reset sequence input is high.
- ST_HALT goes to ST_WAIT when that input drops.
- ST_WAIT goes to ST_LOW when the synchronized strobe is low.
- ST_LOW goes to ST_COMMIT on a strobe rise with chip select low.
- ST_LOW goes to ST_WAIT on a strobe rise with chip select high.
- ST_COMMIT goes to ST_WAIT.

Top module: `pwf_top`

## Requirements
- R1: A write is taken only on a rising edge of the write strobe (`wr_n_i` going 0 to 1) while chip select `cs_n_i` is low. A strobe that completes with chip select high produces no command.
- R2: The 12-bit data word reaches `cmd_data_o` unchanged, with bit 11 as the MSB.
- R3: The register-type code is passed on `cmd_type_o`: 2'b00 is special function, 2'b01 is gain, 2'b10 is offset and 2'b11 is input data. A gain, offset or data write to a channel address of 40 or more is discarded. A special-function write is kept for any address.
- R4: In toggle mode (`toggle_en_i`=1), a data write (type 2'b11) carries `cmd_bank_o` equal to `bank_sel_i`, where 1 means bank B and 0 means bank A.
- R5: In normal mode, every data write carries `cmd_bank_o`=0 (bank A). Gain, offset and special-function writes always carry `cmd_bank_o`=0.
- R6: Up to 8 writes are queued while `cmd_ready_i` is low, and they are delivered in arrival order.
- R7: A write that arrives while the queue holds 8 entries is discarded. It also sets `overflow_o`, which stays at 1 until `rst_n` is asserted.
- R8: While `reset_seq_i` is 1, the queue is emptied and no write is captured.
- R9: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the command fields and `cmd_valid_o` hold their values.
- R10: After `rst_n`, `cmd_valid_o` and `overflow_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, taken on its rise |
| data_i | input | 12 | Data word |
| chan_i | input | 6 | Channel or special-function address |
| rtype_i | input | 2 | Register-type code |
| bank_sel_i | input | 1 | Bank select for data writes in toggle mode |
| toggle_en_i | input | 1 | Toggle mode enable, synchronous |
| reset_seq_i | input | 1 | Internal reset sequence running, synchronous |
| cmd_ready_i | input | 1 | Engine can accept the head command |
| cmd_valid_o | output | 1 | Head command present |
| cmd_data_o | output | 12 | Head command data |
| cmd_chan_o | output | 6 | Head command address |
| cmd_type_o | output | 2 | Head command register type |
| cmd_bank_o | output | 1 | Head command bank, 0 is A and 1 is B |
| overflow_o | output | 1 | Sticky flag for a write lost to a full queue |

## Verification
A write pointer or count that has gone wrong shows up as a missing, duplicated or out-of-order command when the queue is drained. It also shows as an early or late `overflow_o` on the ninth queued write. A wrong capture state shows as a command from a deselected strobe, or as a missing command, about five clocks after the strobe rises. A wrong bank or range decode appears on the head fields as soon as the entry reaches the front of the queue. A flush that fails leaves `cmd_valid_o` high one clock after `reset_seq_i` rises.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
    localparam int DATA_W  = 12;
    localparam int ADDR_W  = 6;
    localparam int ENTRY_W = 48;
    localparam int PAD_W   = ENTRY_W - DATA_W - ADDR_W - 3;

    typedef enum logic [1:0] {
        RT_SPECIAL = 2'b00,
        RT_GAIN    = 2'b01,
        RT_OFFSET  = 2'b10,
        RT_DATA    = 2'b11
    } rtype_e;

    typedef struct packed {
        logic [PAD_W-1:0]  pad;
        logic              bank;
        rtype_e            rtype;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_entry_t;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_LOW    = 2'd2,
        ST_COMMIT = 2'd3
    } cap_state_e;
endpackage

// File: rtl/pwf_sync.sv
module pwf_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwf_fifo.sv
module pwf_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         drop_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign empty_o = (count_q == '0);
    assign do_pop  = pop_i && !empty_o;
    assign do_push = push_i && (!full_o || do_pop);
    assign drop_o  = push_i && !do_push;
    assign rdata_o = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (do_push && !flush_i) mem[wr_ptr_q] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R6: occupancy never passes the depth
    always_comb begin
        a_r6_count_bound: assert (count_q <= CNT_W'(DEPTH));
    end

    // R7: a lost write leaves the occupancy unchanged
    a_r7_drop_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_o && !flush_i) |=> (count_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/pwf_capture.sv
module pwf_capture
    import pwf_pkg::*;
#(
    parameter int NUM_CHAN = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_seq_i,
    input  logic              toggle_en_i,
    input  logic              cs_n_s,
    input  logic              wr_n_s,
    input  logic              bank_sel_s,
    input  logic [1:0]        rtype_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              push_o,
    output wr_entry_t         entry_o
);
    cap_state_e state_q, state_d;
    wr_entry_t  hold_q;
    logic       keep_q;
    logic       take;
    logic       addr_ok;
    logic       bank_d;

    assign take    = (state_q == ST_LOW) && wr_n_s && !cs_n_s && !reset_seq_i;
    assign addr_ok = (rtype_s == RT_SPECIAL) || (int'(addr_s) < NUM_CHAN);
    assign bank_d  = (rtype_s == RT_DATA) && toggle_en_i && bank_sel_s;

    always_comb begin
        state_d = state_q;
        if (reset_seq_i) begin
            state_d = ST_HALT;
        end else begin
            unique case (state_q)
                ST_HALT:   state_d = ST_WAIT;
                ST_WAIT:   if (!wr_n_s) state_d = ST_LOW;
                ST_LOW:    if (wr_n_s)  state_d = cs_n_s ? ST_WAIT : ST_COMMIT;
                ST_COMMIT: state_d = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            keep_q <= 1'b0;
        end else if (take) begin
            hold_q.pad   <= '0;
            hold_q.bank  <= bank_d;
            hold_q.rtype <= rtype_e'(rtype_s);
            hold_q.addr  <= addr_s;
            hold_q.data  <= data_s;
            keep_q       <= addr_ok;
        end
    end

    always_comb begin
        push_o  = (state_q == ST_COMMIT) && keep_q && !reset_seq_i;
        entry_o = hold_q;
    end

    // R8: nothing is captured during a reset sequence
    a_r8_halt_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seq_i |-> !push_o);

    // R1: every push follows a completed strobe
    a_r1_push_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> ($past(state_q) == ST_LOW));
endmodule

// File: rtl/pwf_top.sv
module pwf_top
    import pwf_pkg::*;
#(
    parameter int NUM_CHAN    = 40,
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] chan_i,
    input  logic [1:0]        rtype_i,
    input  logic              bank_sel_i,
    input  logic              toggle_en_i,
    input  logic              reset_seq_i,
    input  logic              cmd_ready_i,
    output logic              cmd_valid_o,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic [ADDR_W-1:0] cmd_chan_o,
    output logic [1:0]        cmd_type_o,
    output logic              cmd_bank_o,
    output logic              overflow_o
);
    localparam int BUS_W = DATA_W + ADDR_W + 5;
    localparam logic [BUS_W-1:0] BUS_RST = {2'b11, {(BUS_W-2){1'b0}}};

    logic [BUS_W-1:0]  bus_raw, bus_s;
    logic              cs_n_s, wr_n_s, bank_sel_s;
    logic [1:0]        rtype_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              push;
    wr_entry_t         entry_in, entry_out;
    logic              empty, full, drop, pop;
    logic              ovf_q;

    assign bus_raw = {cs_n_i, wr_n_i, bank_sel_i, rtype_i, chan_i, data_i};

    pwf_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_raw),
        .q_o   (bus_s)
    );

    assign {cs_n_s, wr_n_s, bank_sel_s, rtype_s, addr_s, data_s} = bus_s;

    pwf_capture #(.NUM_CHAN(NUM_CHAN)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_seq_i (reset_seq_i),
        .toggle_en_i (toggle_en_i),
        .cs_n_s      (cs_n_s),
        .wr_n_s      (wr_n_s),
        .bank_sel_s  (bank_sel_s),
        .rtype_s     (rtype_s),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .push_o      (push),
        .entry_o     (entry_in)
    );

    assign pop = cmd_ready_i && !empty;

    pwf_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (reset_seq_i),
        .push_i  (push),
        .wdata_i (entry_in),
        .pop_i   (pop),
        .rdata_o (entry_out),
        .empty_o (empty),
        .full_o  (full),
        .drop_o  (drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ovf_q <= 1'b0;
        else if (drop) ovf_q <= 1'b1;
    end

    always_comb begin
        cmd_valid_o = !empty;
        cmd_data_o  = entry_out.data;
        cmd_chan_o  = entry_out.addr;
        cmd_type_o  = entry_out.rtype;
        cmd_bank_o  = entry_out.bank;
        overflow_o  = ovf_q;
    end

    // R7: overflow flag is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R9: head holds while stalled
    a_r9_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i && !reset_seq_i) |=>
            (cmd_valid_o && $stable(cmd_data_o) && $stable(cmd_chan_o)
             && $stable(cmd_type_o) && $stable(cmd_bank_o)));

    // R5: only data writes may name bank B
    a_r5_bank_a_non_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_type_o != RT_DATA) |-> !cmd_bank_o);

    // R3: channel registers stay within range
    a_r3_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_type_o != RT_SPECIAL) |-> (int'(cmd_chan_o) < NUM_CHAN));

    always_comb begin
        if (cmd_valid_o) a_pad_zero: assert (entry_out.pad == '0);
    end
endmodule

// File: tb/pwf_top_test.sv
module pwf_top_test;
    localparam int PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1;
    logic [11:0] data = '0;
    logic [5:0]  chan = '0;
    logic [1:0]  rtype = '0;
    logic        bank_sel = 1'b0, toggle_en = 1'b0, reset_seq = 1'b0, ready = 1'b0;
    logic        valid, bank, ovf;
    logic [11:0] q_data;
    logic [5:0]  q_chan;
    logic [1:0]  q_type;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pwf_top uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wr_n_i(wr_n), .data_i(data),
        .chan_i(chan), .rtype_i(rtype), .bank_sel_i(bank_sel), .toggle_en_i(toggle_en),
        .reset_seq_i(reset_seq), .cmd_ready_i(ready), .cmd_valid_o(valid),
        .cmd_data_o(q_data), .cmd_chan_o(q_chan), .cmd_type_o(q_type),
        .cmd_bank_o(bank), .overflow_o(ovf)
    );

    typedef struct packed {
        logic [11:0] d;
        logic [5:0]  a;
        logic [1:0]  t;
        logic        bsel;
        logic        tog;
        logic        keep;
        logic        ebank;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{12'hFFF, 6'd0,  2'b11, 1'b0, 1'b0, 1'b1, 1'b0},
        '{12'h000, 6'd39, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1},
        '{12'h5A5, 6'd5,  2'b11, 1'b0, 1'b1, 1'b1, 1'b0},
        '{12'h123, 6'd7,  2'b11, 1'b1, 1'b0, 1'b1, 1'b0},
        '{12'h800, 6'd12, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0},
        '{12'h001, 6'd20, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0},
        '{12'h3C3, 6'd40, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0},
        '{12'h7E7, 6'd63, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0},
        '{12'h456, 6'd45, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [11:0] d, input logic [5:0] a,
                            input logic [1:0] t, input logic b, input logic sel);
        @(negedge clk);
        data = d; chan = a; rtype = t; bank_sel = b; cs_n = !sel; wr_n = 1'b0;
        cycles(3);
        wr_n = 1'b1;
        cycles(3);
        cs_n = 1'b1;
        cycles(3);
    endtask

    task automatic pop_check(input logic [11:0] d, input logic [5:0] a,
                             input logic [1:0] t, input logic b, input string req);
        chk(valid == 1'b1, req, valid, 1);
        chk(q_data == d, req, q_data, d);
        chk(q_chan == a, req, q_chan, a);
        chk(q_type == t, req, q_type, t);
        chk(bank == b, req, bank, b);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        // R10 reset state
        chk(valid == 1'b0, "R10 valid", valid, 0);
        chk(ovf == 1'b0, "R10 overflow", ovf, 0);

        // Table: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            toggle_en = VECS[v].tog;
            do_write(VECS[v].d, VECS[v].a, VECS[v].t, VECS[v].bsel, 1'b1);
            if (VECS[v].keep)
                pop_check(VECS[v].d, VECS[v].a, VECS[v].t, VECS[v].ebank, "R2/R3/R4/R5 vector");
            else
                chk(valid == 1'b0, "R3 out-of-range dropped", valid, 0);
            chk(valid == 1'b0, "R6 single entry drained", valid, 0);
        end
        toggle_en = 1'b0;

        // R1: deselected strobe ignored
        do_write(12'hABC, 6'd3, 2'b11, 1'b0, 1'b0);
        chk(valid == 1'b0, "R1 cs high ignored", valid, 0);

        // R9: head stable while stalled
        do_write(12'h111, 6'd1, 2'b10, 1'b0, 1'b1);
        do_write(12'h222, 6'd2, 2'b01, 1'b0, 1'b1);
        cycles(5);
        chk(q_data == 12'h111 && valid, "R9 head held", q_data, 12'h111);
        pop_check(12'h111, 6'd1, 2'b10, 1'b0, "R9 first");
        pop_check(12'h222, 6'd2, 2'b01, 1'b0, "R9 second");

        // R6 / R7: fill, overflow, drain in order
        for (int i = 0; i < 8; i++)
            do_write(12'h100 + 12'(i), 6'(i), 2'b11, 1'b0, 1'b1);
        chk(ovf == 1'b0, "R7 no overflow at eight", ovf, 0);
        do_write(12'hEEE, 6'd9, 2'b11, 1'b0, 1'b1);
        chk(ovf == 1'b1, "R7 overflow on ninth", ovf, 1);
        for (int i = 0; i < 8; i++)
            pop_check(12'h100 + 12'(i), 6'(i), 2'b11, 1'b0, "R6 order");
        chk(valid == 1'b0, "R7 ninth dropped", valid, 0);
        chk(ovf == 1'b1, "R7 overflow sticky", ovf, 1);

        // R8: flush and ignore during reset sequence
        do_write(12'h333, 6'd3, 2'b11, 1'b0, 1'b1);
        do_write(12'h444, 6'd4, 2'b11, 1'b0, 1'b1);
        reset_seq = 1'b1;
        cycles(2);
        chk(valid == 1'b0, "R8 flushed", valid, 0);
        do_write(12'h555, 6'd5, 2'b11, 1'b0, 1'b1);
        chk(valid == 1'b0, "R8 write ignored", valid, 0);
        reset_seq = 1'b0;
        cycles(6);
        chk(valid == 1'b0, "R8 nothing after release", valid, 0);
        do_write(12'h666, 6'd6, 2'b10, 1'b0, 1'b1);
        pop_check(12'h666, 6'd6, 2'b10, 1'b0, "R8 resumes");

        // R7 / R10: reset clears overflow
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(2);
        chk(ovf == 1'b0, "R7 overflow cleared by reset", ovf, 0);
        chk(valid == 1'b0, "R10 valid after reset", valid, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule